// File: doc/BRIEF.md
# Partitioned SIMD Magnitude Comparator

This block compares two 16-bit operands as one, two or four independent unsigned lanes. A small partition mask chooses the lane split at run time by cutting the compare chain at nibble boundaries. The block produces all six relations at once: equal, not-equal, less-than, less-or-equal, greater-than and greater-or-equal.

Each relation comes out as a 4-bit flag vector with one bit for each nibble position. Every nibble bit inside a lane carries that lane's result, so a downstream per-nibble select can use the flags directly. The block is purely combinational and has no clock or reset. Operands and mask are plain inputs, not streams, so no valid/ready handshake applies.

Top module: `simd_lane_cmp`

## Requirements
- R1: With mask 4'b0000 the operands form one 16-bit unsigned lane, and all four bits of each flag vector equal that lane's relation result.
- R2: With mask 4'b0010 there are two 8-bit lanes. Flag bits 1:0 report operand bits 7:0 and flag bits 3:2 report operand bits 15:8.
- R3: With mask 4'b1111 there are four 4-bit lanes. Flag bit i reports operand bits 4i+3:4i.
- R4: Mask bit 0 cuts the chain between bits 3 and 4, bit 1 between bits 7 and 8, and bit 2 between bits 11 and 12. Any mask pattern forms lanes from exactly the cuts it enables.
- R5: Mask bit 3 has no effect on any output.
- R6: A lane's result depends only on the operand bits inside that lane, and compares them as an unsigned number.
- R7: For every flag bit, exactly one of lt, eq and gt is set. ne is the inverse of eq, le is lt or eq, and ge is gt or eq.
- R8: All flag bits that belong to the same lane carry the same value in every relation.
- R9: Outputs follow the inputs with no clock: a new operand pair is reflected as soon as it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| part_mask_i | input | 4 | Lane cut enables (bit k cuts above nibble k) |
| eq_o | output | 4 | A equals B, per nibble |
| ne_o | output | 4 | A differs from B, per nibble |
| lt_o | output | 4 | A below B, per nibble |
| le_o | output | 4 | A at most B, per nibble |
| gt_o | output | 4 | A above B, per nibble |
| ge_o | output | 4 | A at least B, per nibble |

## Verification
The assertions assume that every input is a known 0 or 1 whenever they evaluate, because the relations among the flag vectors are only defined for two-state operands and mask. The bench drives only fully specified values: directed pairs such as 0xABCD against 0xABCE, 0x8000 against 0x0000 and 0xBEEF against 0xFEED, and seeded random operands under all sixteen mask patterns. It drives these values only after the inputs have first been set to zero.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

  // Partial relation of a group of bits: equal, or A strictly above B.
  typedef struct packed {
    logic eq;
    logic gt;
  } rel_t;

  // Merge a more significant group (hi) with the result of the less
  // significant bits below it (lo).
  function automatic rel_t rel_merge(rel_t hi, rel_t lo);
    rel_t r;
    r.eq = hi.eq & lo.eq;
    r.gt = hi.gt | (hi.eq & lo.gt);
    return r;
  endfunction

endpackage

// File: rtl/nib_rel.sv
module nib_rel #(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0]      a_i,
  input  logic [NIB_W-1:0]      b_i,
  output simd_cmp_pkg::rel_t    rel_o
);
  always_comb begin
    rel_o.eq = (a_i == b_i);
    rel_o.gt = (a_i > b_i);
  end
endmodule

// File: rtl/lane_prefix.sv
module lane_prefix #(
  parameter int LANES = 4
) (
  input  simd_cmp_pkg::rel_t [LANES-1:0] nib_i,
  input  logic [LANES-1:0]               start_i,
  output simd_cmp_pkg::rel_t [LANES-1:0] acc_o
);
  import simd_cmp_pkg::*;

  // Accumulate upward from each lane's lowest nibble.
  assign acc_o[0] = nib_i[0];
  for (genvar i = 1; i < LANES; i++) begin : g_up
    assign acc_o[i] = start_i[i] ? nib_i[i] : rel_merge(nib_i[i], acc_o[i-1]);
  end
endmodule

// File: rtl/lane_spread.sv
module lane_spread #(
  parameter int LANES = 4
) (
  input  simd_cmp_pkg::rel_t [LANES-1:0] acc_i,
  input  logic [LANES-1:0]               top_i,
  output simd_cmp_pkg::rel_t [LANES-1:0] lane_o
);
  // Copy each lane's top-nibble result down across the lane.
  assign lane_o[LANES-1] = acc_i[LANES-1];
  for (genvar i = 0; i < LANES-1; i++) begin : g_down
    assign lane_o[i] = top_i[i] ? acc_i[i] : lane_o[i+1];
  end
endmodule

// File: rtl/rel_decode.sv
module rel_decode #(
  parameter int LANES = 4
) (
  input  simd_cmp_pkg::rel_t [LANES-1:0] lane_i,
  output logic [LANES-1:0]               eq_o,
  output logic [LANES-1:0]               ne_o,
  output logic [LANES-1:0]               lt_o,
  output logic [LANES-1:0]               le_o,
  output logic [LANES-1:0]               gt_o,
  output logic [LANES-1:0]               ge_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_dec
    assign eq_o[i] = lane_i[i].eq;
    assign gt_o[i] = lane_i[i].gt;
    assign ne_o[i] = ~lane_i[i].eq;
    assign lt_o[i] = ~lane_i[i].eq & ~lane_i[i].gt;
    assign le_o[i] = ~lane_i[i].gt;
    assign ge_o[i] = lane_i[i].eq | lane_i[i].gt;
  end
endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp #(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4,
  localparam int LANES = DATA_W / NIB_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [LANES-1:0]  part_mask_i,
  output logic [LANES-1:0]  eq_o,
  output logic [LANES-1:0]  ne_o,
  output logic [LANES-1:0]  lt_o,
  output logic [LANES-1:0]  le_o,
  output logic [LANES-1:0]  gt_o,
  output logic [LANES-1:0]  ge_o
);
  import simd_cmp_pkg::*;

  rel_t [LANES-1:0] nib_rel_w;
  rel_t [LANES-1:0] acc_w;
  rel_t [LANES-1:0] lane_w;
  logic [LANES-1:0] start_w;
  logic [LANES-1:0] top_w;
  logic             unused_top_cut;

  // The top mask bit would cut above the last nibble: no boundary exists.
  assign unused_top_cut = part_mask_i[LANES-1];

  assign start_w = {part_mask_i[LANES-2:0], 1'b1};
  assign top_w   = {1'b1, part_mask_i[LANES-2:0]};

  for (genvar i = 0; i < LANES; i++) begin : g_nib
    nib_rel #(.NIB_W(NIB_W)) u_nib (
      .a_i   (a_i[i*NIB_W +: NIB_W]),
      .b_i   (b_i[i*NIB_W +: NIB_W]),
      .rel_o (nib_rel_w[i])
    );
  end

  lane_prefix #(.LANES(LANES)) u_prefix (
    .nib_i   (nib_rel_w),
    .start_i (start_w),
    .acc_o   (acc_w)
  );

  lane_spread #(.LANES(LANES)) u_spread (
    .acc_i  (acc_w),
    .top_i  (top_w),
    .lane_o (lane_w)
  );

  rel_decode #(.LANES(LANES)) u_dec (
    .lane_i (lane_w),
    .eq_o   (eq_o),
    .ne_o   (ne_o),
    .lt_o   (lt_o),
    .le_o   (le_o),
    .gt_o   (gt_o),
    .ge_o   (ge_o)
  );
endmodule

// File: rtl/simd_lane_cmp_chk.sv
module simd_lane_cmp_chk #(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4,
  localparam int LANES = DATA_W / NIB_W
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [LANES-1:0]  part_mask_i,
  input logic [LANES-1:0]  eq_o,
  input logic [LANES-1:0]  ne_o,
  input logic [LANES-1:0]  lt_o,
  input logic [LANES-1:0]  le_o,
  input logic [LANES-1:0]  gt_o,
  input logic [LANES-1:0]  ge_o
);
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      // R7
      rel_onehot_chk: assert ($countones({lt_o[i], eq_o[i], gt_o[i]}) == 1);
      // R7
      rel_derived_chk: assert ((ne_o[i] == !eq_o[i]) && (le_o[i] == (lt_o[i] | eq_o[i]))
                               && (ge_o[i] == (gt_o[i] | eq_o[i])));
    end
    for (int k = 0; k < LANES-1; k++) begin
      // R8
      lane_uniform_chk: assert (part_mask_i[k] ||
        ({eq_o[k], gt_o[k]} == {eq_o[k+1], gt_o[k+1]}));
    end
    // R3
    if (&part_mask_i[LANES-2:0]) begin
      for (int i = 0; i < LANES; i++) begin
        nib_lane_chk: assert ((eq_o[i] == (a_i[i*NIB_W +: NIB_W] == b_i[i*NIB_W +: NIB_W]))
                              && (gt_o[i] == (a_i[i*NIB_W +: NIB_W] > b_i[i*NIB_W +: NIB_W])));
      end
    end
    // R1
    if (part_mask_i[LANES-2:0] == '0) begin
      full_lane_chk: assert ((eq_o[0] == (a_i == b_i)) && (gt_o[0] == (a_i > b_i)));
    end
  end
endmodule

bind simd_lane_cmp simd_lane_cmp_chk #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_chk (
  .a_i(a_i), .b_i(b_i), .part_mask_i(part_mask_i),
  .eq_o(eq_o), .ne_o(ne_o), .lt_o(lt_o), .le_o(le_o), .gt_o(gt_o), .ge_o(ge_o)
);

// File: tb/simd_lane_cmp_test.sv
module simd_lane_cmp_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NW = 4;
  localparam int NL = DW / NW;
  localparam int WATCHDOG_CYC = 100000;

  logic          clk = 1'b0;
  logic [DW-1:0] a, b;
  logic [NL-1:0] mask;
  logic [NL-1:0] eq, ne, lt, le, gt, ge;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_lane_cmp uut (
    .a_i(a), .b_i(b), .part_mask_i(mask),
    .eq_o(eq), .ne_o(ne), .lt_o(lt), .le_o(le), .gt_o(gt), .ge_o(ge)
  );

  // Reference: {eq, ne, lt, le, gt, ge}, each NL bits.
  function automatic logic [6*NL-1:0] ref_flags(logic [DW-1:0] x, logic [DW-1:0] y,
                                                logic [NL-1:0] m);
    logic [NL-1:0] e, n, l, le_v, g, ge_v;
    for (int i = 0; i < NL; i++) begin
      int lo = i;
      int hi = i;
      longint unsigned xv = 0;
      longint unsigned yv = 0;
      while (lo > 0 && !m[lo-1]) lo--;
      while (hi < NL-1 && !m[hi]) hi++;
      for (int j = hi*NW + NW - 1; j >= lo*NW; j--) begin
        xv = (xv << 1) | longint'(x[j]);
        yv = (yv << 1) | longint'(y[j]);
      end
      e[i] = (xv == yv); n[i] = (xv != yv);
      l[i] = (xv < yv);  le_v[i] = (xv <= yv);
      g[i] = (xv > yv);  ge_v[i] = (xv >= yv);
    end
    return {e, n, l, le_v, g, ge_v};
  endfunction

  task automatic check(string tag, logic [DW-1:0] x, logic [DW-1:0] y, logic [NL-1:0] m);
    logic [6*NL-1:0] exp_v, act_v;
    a = x; b = y; mask = m;
    #(CLK_PERIOD/2);
    exp_v = ref_flags(x, y, m);
    act_v = {eq, ne, lt, le, gt, ge};
    n_run++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h mask=%b actual=%h expected=%h", tag, x, y, m, act_v, exp_v);
    end
  endtask

  task automatic check_val(string tag, logic [NL-1:0] act, logic [NL-1:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp_v);
    end
  endtask

  initial begin : wd
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [DW-1:0] dir_a [3];
    logic [DW-1:0] dir_b [3];
    logic [NL-1:0] modes [3];
    int unused_seed;
    dir_a = '{16'hABCD, 16'h8000, 16'hBEEF};
    dir_b = '{16'hABCE, 16'h0000, 16'hFEED};
    modes = '{4'b0000, 4'b0010, 4'b1111};
    unused_seed = $urandom(32'h5EED_1234);

    // Reset-like start: zero inputs give equal in every nibble.
    a = '0; b = '0; mask = '0;
    @(negedge clk);
    check_val("R1 zero eq", eq, 4'b1111);
    check_val("R7 zero ne", ne, 4'b0000);

    // R1: directed single lane values.
    a = 16'h8000; b = 16'h0000; mask = 4'b0000; #1;
    check_val("R1 8000>0000 gt", gt, 4'b1111);
    a = 16'hABCD; b = 16'hABCE; #1;
    check_val("R1 ABCD<ABCE lt", lt, 4'b1111);
    // R2: two byte lanes, BEEF vs FEED -> low EF>ED, high BE<FE.
    a = 16'hBEEF; b = 16'hFEED; mask = 4'b0010; #1;
    check_val("R2 BEEF/FEED gt", gt, 4'b0011);
    check_val("R2 BEEF/FEED lt", lt, 4'b1100);
    // R3: four nibbles, BEEF vs FEED -> F>D, E=E, E<E? nib1 E vs E eq, nib2 E vs E eq, nib3 B<F.
    mask = 4'b1111; #1;
    check_val("R3 BEEF/FEED gt", gt, 4'b0001);
    check_val("R3 BEEF/FEED eq", eq, 4'b0110);
    // R9: operands change without any clock edge.
    a = 16'h0000; b = 16'hFFFF; #1;
    check_val("R9 comb lt", lt, 4'b1111);

    // Required pairs under all three named modes.
    for (int p = 0; p < 3; p++)
      for (int md = 0; md < 3; md++) begin
        check("R1 R2 R3 pair", dir_a[p], dir_b[p], modes[md]);
        check("R6 swapped", dir_b[p], dir_a[p], modes[md]);
      end

    // R6: high lane differs only; low lane must still read equal.
    a = 16'hF012; b = 16'h0012; mask = 4'b0010; #1;
    check_val("R6 outside bits", eq, 4'b0011);

    // R5: mask bit 3 toggled gives identical flags.
    for (int k = 0; k < 40; k++) begin
      logic [DW-1:0] ra, rb;
      logic [NL-1:0] rm;
      logic [6*NL-1:0] f0;
      ra = DW'($urandom); rb = DW'($urandom); rm = NL'($urandom) & 4'b0111;
      a = ra; b = rb; mask = rm; #1;
      f0 = {eq, ne, lt, le, gt, ge};
      mask = rm | 4'b1000; #1;
      n_run++;
      if ({eq, ne, lt, le, gt, ge} !== f0) begin
        n_fail++;
        $display("FAIL R5 actual=%h expected=%h", {eq, ne, lt, le, gt, ge}, f0);
      end
    end

    // R4 R7 R8: random operands under every mask pattern.
    for (int m = 0; m < 16; m++)
      for (int k = 0; k < 200; k++) begin
        logic [DW-1:0] ra, rb;
        ra = DW'($urandom);
        rb = ($urandom % 4 == 0) ? (ra ^ DW'(1 << ($urandom % DW))) : DW'($urandom);
        check("R4 R7 R8 random", ra, rb, NL'(m));
      end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule